// File: doc/BRIEF.md
# Serial Programming Entry Key Detector

This block sits on the target side of a serial programming link. It watches three pins: the programming reset line, the programming clock and the programming data line. It decides whether an external programmer has performed a valid entry into programming mode. All three pins are brought into the system clock domain through a synchronizer. Edges are then detected on the synchronized levels.

An entry attempt starts with a short high pulse on the reset line. While reset is low again, the data line is sampled on every rising edge of the programming clock, least significant bit first. When reset rises, the attempt is accepted only if exactly 32 bits were collected and they equal the entry key. The mode-active output then goes high. After entry, a guard window of system clock cycles must pass with no programming clock activity. The next 68 clock rises carry two setup frames. Each frame is two zero bits followed by a 32-bit word, and both words are presented on an output once complete. Holding reset low for a parameterized number of system clock cycles ends the mode and clears every output.

The setup words are held results that stay valid while the mode lasts. They are not a stream, so the block has no valid/ready handshake and no back-pressure. All pins are plain levels.

Top module: `prog_entry_detect`

## Requirements
- R1: After system reset, mode_active, setup_done, frame_err and proto_err are 0 and setup_words is all zeros.
- R2: Entry is accepted under the following sequence: a rise on prog_rst, then a fall, then exactly 32 prog_clk rising edges with prog_dat sampled on each, least significant bit first, forming 0x8A12C2B2, then a rise on prog_rst. After acceptance, mode_active goes high.
- R3: An attempt whose 32 collected bits differ from 0x8A12C2B2 leaves mode_active low.
- R4: An attempt with 31 or 33 clock rises before the prog_rst rise leaves mode_active low, whatever the data.
- R5: A prog_clk rise in the same system cycle as the prog_rst rise that closes an attempt is counted as a key bit before the acceptance decision.
- R6: Key bits clocked in while prog_rst has stayed low since system reset, with no preceding high pulse, are not accepted.
- R7: A prog_clk rise within WAIT_CYCLES system cycles after entry sets proto_err, and that edge is not taken as a setup bit.
- R8: After the guard window, 68 prog_clk rises form two frames of 2 pad bits plus 32 data bits each. Each word is assembled least significant bit first. Frame 0 appears on setup_words[31:0] and frame 1 on setup_words[63:32]. setup_done rises after the 68th bit.
- R9: frame_err goes high if any of the four pad bits is 1.
- R10: prog_rst held low for EXIT_CYCLES consecutive system cycles drops mode_active and clears all outputs. A shorter low interval has no effect.
- R11: prog_clk rises after setup_done leave setup_words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| prog_rst | input | 1 | Programming reset line (asynchronous) |
| prog_clk | input | 1 | Programming clock (asynchronous) |
| prog_dat | input | 1 | Programming data line (asynchronous) |
| mode_active | output | 1 | Programming mode entered |
| setup_done | output | 1 | Both setup frames received |
| setup_words | output | N_FRAMES*KEY_W | Received setup words, frame 0 in the low word |
| frame_err | output | 1 | A frame pad bit was nonzero |
| proto_err | output | 1 | Clock edge seen inside the post-entry guard window |

## Verification
The acceptance decision and the final key bit can land in the same system cycle. This happens when the last programming clock rise and the reset rise are driven together, so both leave the synchronizer on the same edge. The bench provokes this twice. In the first case, 31 ordinary bits are followed by a simultaneous edge, and entry must be accepted. In the second case, 32 ordinary bits are followed by a simultaneous edge, making 33 counted bits, and entry must be refused. Random trials also mix the simultaneous and separated forms with 31, 32 or 33 bits. Each trial is judged by mode_active against a bench-computed verdict.

// File: rtl/entry_det_pkg.sv
package entry_det_pkg;
  localparam logic [31:0] ENTRY_KEY = 32'h8A12C2B2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_SHIFT,
    ST_ACTIVE
  } det_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic reached
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign reached = run && (cnt == LAST);
endmodule

// File: rtl/setup_rx.sv
module setup_rx #(
  parameter int PAD_W    = 2,
  parameter int WORD_W   = 32,
  parameter int N_FRAMES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       bit_en,
  input  logic                       bit_in,
  output logic [N_FRAMES*WORD_W-1:0] words,
  output logic                       err,
  output logic                       done
);
  localparam int FRAME_W = PAD_W + WORD_W;
  localparam int PW      = $clog2(FRAME_W);
  localparam int FW      = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_W - 1);
  localparam logic [PW-1:0] PAD_END  = PW'(PAD_W);
  localparam logic [FW-1:0] F_LAST   = FW'(N_FRAMES - 1);

  logic [PW-1:0] pos;
  logic [FW-1:0] fidx;
  logic          take;

  assign take = bit_en && !done;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos  <= '0;
      fidx <= '0;
      err  <= 1'b0;
      done <= 1'b0;
    end else if (take) begin
      if (pos < PAD_END) err <= err | bit_in;
      if (pos == POS_LAST) begin
        pos <= '0;
        if (fidx == F_LAST) done <= 1'b1;
        else fidx <= fidx + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_word
    logic [WORD_W-1:0] w;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) w <= '0;
      else if (take && pos >= PAD_END && fidx == FW'(g))
        w <= {bit_in, w[WORD_W-1:1]};
    end
    assign words[g*WORD_W +: WORD_W] = w;
  end
endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect
  import entry_det_pkg::*;
#(
  parameter int              KEY_W       = 32,
  parameter logic [KEY_W-1:0] KEY        = ENTRY_KEY,
  parameter int              PAD_W       = 2,
  parameter int              N_FRAMES    = 2,
  parameter int              SYNC_STAGES = 2,
  parameter int              WAIT_CYCLES = 62500,
  parameter int              EXIT_CYCLES = 125000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_rst,
  input  logic                      prog_clk,
  input  logic                      prog_dat,
  output logic                      mode_active,
  output logic                      setup_done,
  output logic [N_FRAMES*KEY_W-1:0] setup_words,
  output logic                      frame_err,
  output logic                      proto_err
);
  localparam int CNT_W = $clog2(KEY_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(KEY_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(KEY_W + 1);

  logic [2:0] pins_s;
  logic       rst_lvl, clk_lvl, dat_lvl;
  logic       rst_prev, clk_prev;
  logic       rst_rise, rst_fall, clk_rise;

  pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({prog_dat, prog_clk, prog_rst}),
    .q    (pins_s)
  );

  assign {dat_lvl, clk_lvl, rst_lvl} = pins_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_prev <= 1'b0;
      clk_prev <= 1'b0;
    end else begin
      rst_prev <= rst_lvl;
      clk_prev <= clk_lvl;
    end
  end

  assign rst_rise = rst_lvl && !rst_prev;
  assign rst_fall = !rst_lvl && rst_prev;
  assign clk_rise = clk_lvl && !clk_prev;

  det_state_e       st;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [KEY_W-1:0] key_sr, key_nx;
  logic             accept;
  logic             active;
  logic             wait_over, exit_hit;

  assign active = (st == ST_ACTIVE);

  always_comb begin
    cnt_nx = cnt;
    key_nx = key_sr;
    if (clk_rise) begin
      key_nx = {dat_lvl, key_sr[KEY_W-1:1]};
      if (cnt != CNT_SAT) cnt_nx = cnt + 1'b1;
    end
    accept = (st == ST_SHIFT) && rst_rise && (cnt_nx == CNT_FULL) && (key_nx == KEY);
  end

  hold_timer #(.LIMIT(WAIT_CYCLES)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .reached(wait_over)
  );

  hold_timer #(.LIMIT(EXIT_CYCLES)) u_exit (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active && !rst_lvl),
    .reached(exit_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      key_sr <= '0;
    end else begin
      unique case (st)
        ST_IDLE:  if (rst_rise) st <= ST_PULSE;
        ST_PULSE: if (rst_fall) begin
          st     <= ST_SHIFT;
          cnt    <= '0;
          key_sr <= '0;
        end
        ST_SHIFT: if (rst_rise) begin
          st <= accept ? ST_ACTIVE : ST_PULSE;
        end else begin
          cnt    <= cnt_nx;
          key_sr <= key_nx;
        end
        ST_ACTIVE: if (exit_hit) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active || exit_hit) proto_err <= 1'b0;
    else if (clk_rise && !wait_over) proto_err <= 1'b1;
  end

  setup_rx #(.PAD_W(PAD_W), .WORD_W(KEY_W), .N_FRAMES(N_FRAMES)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!active || exit_hit),
    .bit_en(active && clk_rise && wait_over),
    .bit_in(dat_lvl),
    .words (setup_words),
    .err   (frame_err),
    .done  (setup_done)
  );

  assign mode_active = active;
endmodule

// File: rtl/prog_entry_detect_chk.sv
module prog_entry_detect_chk #(
  parameter int WORDS_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_active,
  input logic               setup_done,
  input logic [WORDS_W-1:0] setup_words,
  input logic               frame_err,
  input logic               proto_err
);
  // R8
  setup_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |-> mode_active);

  // R7
  proto_err_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> mode_active);

  // R9
  frame_err_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> mode_active);

  // R11
  words_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && $past(setup_done)) |-> $stable(setup_words));

  // R10
  exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_active) |-> (!setup_done && !frame_err && !proto_err && setup_words == '0));

  // R2
  clean_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> (!setup_done && !frame_err && !proto_err));
endmodule

bind prog_entry_detect prog_entry_detect_chk #(.WORDS_W(N_FRAMES*KEY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_active(mode_active),
  .setup_done (setup_done),
  .setup_words(setup_words),
  .frame_err  (frame_err),
  .proto_err  (proto_err)
);

// File: tb/sim_prog_entry_detect.sv
`timescale 1ns/1ps
module sim_prog_entry_detect;
  localparam int WAIT_C = 100;
  localparam int EXIT_C = 400;
  localparam logic [31:0] KEY = 32'h8A12C2B2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_rst = 1'b0, prog_clk = 1'b0, prog_dat = 1'b0;
  logic mode_active, setup_done, frame_err, proto_err;
  logic [63:0] setup_words;

  int checks = 0;
  int fails = 0;
  int hp = 4;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prog_entry_detect #(.WAIT_CYCLES(WAIT_C), .EXIT_CYCLES(EXIT_C)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_rst(prog_rst), .prog_clk(prog_clk),
    .prog_dat(prog_dat), .mode_active(mode_active), .setup_done(setup_done),
    .setup_words(setup_words), .frame_err(frame_err), .proto_err(proto_err)
  );

  function automatic bit expect_entry(logic [31:0] k, int nb);
    return (k == KEY) && (nb == 32);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(bit b);
    prog_dat = b;
    idle(hp);
    prog_clk = 1'b1;
    idle(hp);
    prog_clk = 1'b0;
  endtask

  task automatic attempt(logic [31:0] k, int nb, bit simul, bit pulse);
    hp = 3 + int'($urandom % 4);
    if (pulse) begin
      prog_rst = 1'b0; idle(12);
      prog_rst = 1'b1; idle(4);
      prog_rst = 1'b0; idle(6);
    end
    for (int i = 0; i < nb; i++) begin
      if (simul && i == nb - 1) begin
        prog_dat = k[i % 32];
        idle(hp);
        prog_clk = 1'b1;
        prog_rst = 1'b1;
        idle(hp);
        prog_clk = 1'b0;
      end else begin
        send_bit(k[i % 32]);
      end
    end
    if (!simul) begin
      idle(hp);
      prog_rst = 1'b1;
    end
    idle(12);
  endtask

  task automatic send_frame(logic [1:0] pad, logic [31:0] w);
    send_bit(pad[0]);
    send_bit(pad[1]);
    for (int i = 0; i < 32; i++) send_bit(w[i]);
  endtask

  task automatic do_exit();
    prog_rst = 1'b0;
    idle(EXIT_C - 40);
    chk("R10 still active before limit", {63'd0, mode_active}, 64'd1);
    idle(80);
    chk("R10 mode dropped", {63'd0, mode_active}, 64'd0);
    chk("R10 outputs cleared", {setup_words[61:0], setup_done, frame_err | proto_err}, 64'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    logic [31:0] w0, w1, k;
    int nb;
    bit simul, e;
    void'($urandom(32'd20240611));
    idle(5);
    // R1 reset state
    chk("R1 outputs at reset", {setup_words[59:0], mode_active, setup_done, frame_err, proto_err}, 64'd0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 outputs after reset", {setup_words[59:0], mode_active, setup_done, frame_err, proto_err}, 64'd0);

    // R6 no pulse before key
    attempt(KEY, 32, 1'b0, 1'b0);
    chk("R6 no pulse rejected", {63'd0, mode_active}, 64'd0);

    // R2 valid entry, R8 frames, R11, R10
    attempt(KEY, 32, 1'b0, 1'b1);
    chk("R2 entry accepted", {63'd0, mode_active}, 64'd1);
    chk("R8 not done at entry", {63'd0, setup_done}, 64'd0);
    idle(WAIT_C + 20);
    w0 = 32'h00801000; w1 = $urandom;
    send_frame(2'b00, w0);
    send_frame(2'b00, w1);
    idle(8);
    chk("R8 words", setup_words, {w1, w0});
    chk("R8 done", {62'd0, setup_done, frame_err | proto_err}, 64'd2);
    send_frame(2'b11, $urandom);
    idle(8);
    chk("R11 words unchanged", setup_words, {w1, w0});
    prog_rst = 1'b0; idle(EXIT_C / 2); prog_rst = 1'b1; idle(EXIT_C);
    chk("R10 short low ignored", {63'd0, mode_active}, 64'd1);
    do_exit();

    // R7 early clock in guard window
    attempt(KEY, 32, 1'b0, 1'b1);
    send_bit(1'b1);
    idle(4);
    chk("R7 proto_err set", {63'd0, proto_err}, 64'd1);
    idle(WAIT_C + 20);
    w0 = $urandom; w1 = $urandom;
    send_frame(2'b00, w0);
    send_frame(2'b00, w1);
    idle(8);
    chk("R7 early edge not taken", setup_words, {w1, w0});
    do_exit();

    // R9 pad bit error
    attempt(KEY, 32, 1'b0, 1'b1);
    idle(WAIT_C + 20);
    w0 = $urandom; w1 = $urandom;
    send_frame(2'b00, w0);
    send_frame(2'b10, w1);
    idle(8);
    chk("R9 frame_err", {62'd0, frame_err, setup_done}, 64'd3);
    do_exit();

    // R5 simultaneous last edge and reset rise
    attempt(KEY, 32, 1'b1, 1'b1);
    chk("R5 simultaneous 32nd edge accepted", {63'd0, mode_active}, 64'd1);
    do_exit();
    attempt(KEY, 33, 1'b1, 1'b1);
    chk("R5 simultaneous 33rd edge rejected", {63'd0, mode_active}, 64'd0);

    // R4 wrong counts
    attempt(KEY, 31, 1'b0, 1'b1);
    chk("R4 31 bits rejected", {63'd0, mode_active}, 64'd0);
    attempt(KEY, 33, 1'b0, 1'b1);
    chk("R4 33 bits rejected", {63'd0, mode_active}, 64'd0);

    // R3 wrong key
    attempt(KEY ^ 32'h0000_0100, 32, 1'b0, 1'b1);
    chk("R3 wrong key rejected", {63'd0, mode_active}, 64'd0);

    // random mix R2 R3 R4 R5
    for (int t = 0; t < 12; t++) begin
      k = ($urandom % 2) ? KEY : $urandom;
      nb = 31 + int'($urandom % 3);
      simul = 1'($urandom % 2);
      e = expect_entry(k, nb);
      attempt(k, nb, simul, 1'b1);
      chk("R2/R3/R4/R5 random attempt", {63'd0, mode_active}, {63'd0, e});
      if (e) do_exit();
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule